// File: doc/BRIEF.md
# Pin Drive Waveform Formatter

This block shapes the digital control for one tester pin. In each test period it takes a pattern bit for the drive data and a pattern bit for the drive enable. It combines each bit with a pair of timing pulses that belong to its path, and the waveform code chosen for that path decides how they are combined. The block produces three registered control bits for the pin electronics: the level to drive, whether the driver is on, and whether the active load is connected.

Each of the two paths, data and enable, has its own internal timing window. The window opens on the path's open pulse and shuts on its close pulse or at the start of a new period. The window is then combined with the period's pattern bit in one of four ways: non-return, return-to-zero, return-to-one, or complement-surround. Either path can also be held at a constant value. The load follows the driver automatically, connecting whenever the driver is off, or it can be pinned on or off. Pattern symbols that mean "no drive" reach this block as an enable pattern bit of 0.

Top module: `pin_drive_formatter`

## Requirements
- R1: While rst_n is low, drv_data, drv_en and load_en are all 0.
- R2: Each path has its own window. The window is open in the cycle after a clock edge that sees the open pulse, and closed after an edge that sees the close pulse or cyc_start without the open pulse. When the open and close pulses arrive in the same cycle, the window stays closed.
- R3: A path's pattern bit is captured when cyc_start is high and held for the rest of the period. Changes on the pattern input between period starts have no effect on the outputs.
- R4: Code 3'd0 (non-return) outputs the pattern value captured at the most recent open pulse. This value holds across period boundaries until the next open pulse.
- R5: Code 3'd1 (return-to-zero) outputs the period's pattern bit ANDed with the window.
- R6: Code 3'd2 (return-to-one) outputs 1 while the window is closed and the pattern bit while it is open.
- R7: Code 3'd3 (complement-surround) outputs the pattern bit while the window is open and its complement while it is closed.
- R8: Code 3'd4 holds the output at 1 (data high, driver on). Code 3'd5 holds it at 0 (data low, driver off).
- R9: Codes 3'd6 and 3'd7 hold the output at its inactive value 0.
- R10: The data and enable paths are independent. Each has its own code, pattern bit and pulses, and pulses on one path do not move the other path's window.
- R11: Load code 2'd0 makes load_en the complement of drv_en in every cycle. Code 2'd1 holds load_en at 1. Codes 2'd2 and 2'd3 hold it at 0.
- R12: All outputs are registered. A change of any input, including a code, shows at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Pulse marking the first cycle of a test period |
| pat_data | input | 1 | Pattern bit for the drive level |
| pat_en | input | 1 | Pattern bit for the driver enable (0 for no-drive symbols) |
| data_edge_open | input | 1 | Timing pulse that opens the data window |
| data_edge_close | input | 1 | Timing pulse that closes the data window |
| en_edge_open | input | 1 | Timing pulse that opens the enable window |
| en_edge_close | input | 1 | Timing pulse that closes the enable window |
| data_fmt | input | 3 | Waveform code for the data path |
| en_fmt | input | 3 | Waveform code for the enable path |
| load_mode | input | 2 | Load control code |
| drv_data | output | 1 | Level to drive onto the pin |
| drv_en | output | 1 | Driver on |
| load_en | output | 1 | Active load connected |

## Verification
The bench targets the non-return format carrying its last value into a new period. A design that reloads from the period's pattern at cyc_start would show the new bit one cycle too early. It drives the open and close pulses in the same cycle, where a design with the wrong priority would produce a one-cycle glitch in return-to-zero. It changes the pattern input mid-period, which exposes a design that reads the pattern live instead of from the period register. Unused codes, a window left open into the next period, and pulses on only one path round out the list: a design that got these wrong would drive a stray 1, hold a waveform past the period boundary, or let the data and enable paths interfere.

// File: rtl/pin_fmt_pkg.sv
package pin_fmt_pkg;

    localparam int FMT_W  = 3;
    localparam int LOAD_W = 2;

    typedef enum logic [FMT_W-1:0] {
        WAVE_NRZ  = 3'd0,
        WAVE_RZ   = 3'd1,
        WAVE_RTO  = 3'd2,
        WAVE_SURR = 3'd3,
        WAVE_ONE  = 3'd4,
        WAVE_ZERO = 3'd5
    } wave_code_e;

    typedef enum logic [LOAD_W-1:0] {
        LOAD_FOLLOW = 2'd0,
        LOAD_ON     = 2'd1,
        LOAD_OFF    = 2'd2
    } load_code_e;

    typedef struct packed {
        logic open;
    } win_state_t;

    typedef struct packed {
        logic pat;
        logic held;
        logic wave;
    } path_state_t;

    typedef struct packed {
        logic load;
    } top_state_t;

endpackage

// File: rtl/pin_fmt_window.sv
module pin_fmt_window
    import pin_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic edge_open,
    input  logic edge_close,
    output logic win_next,
    output logic win_now
);

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // period start shuts the window; open pulse sets it; close wins over open
        st_d.open = ((st_q.open & ~cyc_start) | edge_open) & ~edge_close;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_next = st_d.open;
    assign win_now  = st_q.open;

endmodule

// File: rtl/pin_fmt_path.sv
module pin_fmt_path
    import pin_fmt_pkg::*;
#(
    parameter int CODE_W = FMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              pat_in,
    input  logic              edge_open,
    input  logic              edge_close,
    input  logic [CODE_W-1:0] code,
    output logic              wave_next,
    output logic              wave_q
);

    path_state_t st_d, st_q;
    logic        win_n;
    logic        win_c;
    logic        pat_eff;

    pin_fmt_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .edge_open  (edge_open),
        .edge_close (edge_close),
        .win_next   (win_n),
        .win_now    (win_c)
    );

    always_comb begin
        st_d    = st_q;
        pat_eff = cyc_start ? pat_in : st_q.pat;
        st_d.pat  = pat_eff;
        st_d.held = edge_open ? pat_eff : st_q.held;
        case (wave_code_e'(code))
            WAVE_NRZ:  st_d.wave = st_d.held;
            WAVE_RZ:   st_d.wave = pat_eff & win_n;
            WAVE_RTO:  st_d.wave = pat_eff | ~win_n;
            WAVE_SURR: st_d.wave = ~(pat_eff ^ win_n);
            WAVE_ONE:  st_d.wave = 1'b1;
            WAVE_ZERO: st_d.wave = 1'b0;
            default:   st_d.wave = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_next = st_d.wave;
    assign wave_q    = st_q.wave;

endmodule

// File: rtl/pin_drive_formatter.sv
module pin_drive_formatter
    import pin_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              pat_data,
    input  logic              pat_en,
    input  logic              data_edge_open,
    input  logic              data_edge_close,
    input  logic              en_edge_open,
    input  logic              en_edge_close,
    input  logic [FMT_W-1:0]  data_fmt,
    input  logic [FMT_W-1:0]  en_fmt,
    input  logic [LOAD_W-1:0] load_mode,
    output logic              drv_data,
    output logic              drv_en,
    output logic              load_en
);

    localparam int PATHS    = 2;
    localparam int IDX_DATA = 0;
    localparam int IDX_EN   = 1;

    logic [PATHS-1:0]            pat_v;
    logic [PATHS-1:0]            open_v;
    logic [PATHS-1:0]            close_v;
    logic [PATHS-1:0][FMT_W-1:0] code_v;
    logic [PATHS-1:0]            wave_n_v;
    logic [PATHS-1:0]            wave_q_v;

    assign pat_v   = {pat_en, pat_data};
    assign open_v  = {en_edge_open, data_edge_open};
    assign close_v = {en_edge_close, data_edge_close};
    assign code_v  = {en_fmt, data_fmt};

    for (genvar p = 0; p < PATHS; p++) begin : g_path
        pin_fmt_path #(
            .CODE_W (FMT_W)
        ) u_path (
            .clk        (clk),
            .rst_n      (rst_n),
            .cyc_start  (cyc_start),
            .pat_in     (pat_v[p]),
            .edge_open  (open_v[p]),
            .edge_close (close_v[p]),
            .code       (code_v[p]),
            .wave_next  (wave_n_v[p]),
            .wave_q     (wave_q_v[p])
        );
    end

    top_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (load_code_e'(load_mode))
            LOAD_FOLLOW: st_d.load = ~wave_n_v[IDX_EN];
            LOAD_ON:     st_d.load = 1'b1;
            default:     st_d.load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_data = wave_q_v[IDX_DATA];
    assign drv_en   = wave_q_v[IDX_EN];
    assign load_en  = st_q.load;

endmodule

// File: rtl/pin_fmt_chk.sv
module pin_fmt_chk
    import pin_fmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_start,
    input logic              data_edge_open,
    input logic              data_edge_close,
    input logic [FMT_W-1:0]  data_fmt,
    input logic [FMT_W-1:0]  en_fmt,
    input logic [LOAD_W-1:0] load_mode,
    input logic              drv_data,
    input logic              drv_en,
    input logic              load_en
);

    // R11
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_mode) == 2'd0) |-> (load_en == !drv_en));

    // R11
    load_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_mode) == 2'd1) |-> load_en);

    // R8
    data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(data_fmt) == 3'd4) |-> drv_data);

    // R8
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_fmt) == 3'd5) |-> !drv_en);

    // R9
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(data_fmt) >= 3'd6) |-> !drv_data);

    // R5
    rz_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(data_fmt) == 3'd1 && $past(data_edge_close)) |-> !drv_data);

    // R6
    rto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(data_fmt) == 3'd2 && $past(cyc_start)
         && !$past(data_edge_open)) |-> drv_data);

endmodule

bind pin_drive_formatter pin_fmt_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cyc_start       (cyc_start),
    .data_edge_open  (data_edge_open),
    .data_edge_close (data_edge_close),
    .data_fmt        (data_fmt),
    .en_fmt          (en_fmt),
    .load_mode       (load_mode),
    .drv_data        (drv_data),
    .drv_en          (drv_en),
    .load_en         (load_en)
);

// File: tb/tb_pin_drive_formatter.sv
`timescale 1ns/1ps
module tb_pin_drive_formatter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       pat_data = 1'b0;
    logic       pat_en = 1'b0;
    logic       data_edge_open = 1'b0;
    logic       data_edge_close = 1'b0;
    logic       en_edge_open = 1'b0;
    logic       en_edge_close = 1'b0;
    logic [2:0] data_fmt = 3'd0;
    logic [2:0] en_fmt = 3'd0;
    logic [1:0] load_mode = 2'd0;
    logic       drv_data;
    logic       drv_en;
    logic       load_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pin_drive_formatter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cyc_start       (cyc_start),
        .pat_data        (pat_data),
        .pat_en          (pat_en),
        .data_edge_open  (data_edge_open),
        .data_edge_close (data_edge_close),
        .en_edge_open    (en_edge_open),
        .en_edge_close   (en_edge_close),
        .data_fmt        (data_fmt),
        .en_fmt          (en_fmt),
        .load_mode       (load_mode),
        .drv_data        (drv_data),
        .drv_en          (drv_en),
        .load_en         (load_en)
    );

    // {code[2:0], pattern, expected output after period cycles 0..3 (MSB first)}
    localparam int NVEC = 14;
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b000_1_0111,  // R4 non-return, previous value 0
        8'b000_0_1000,  // R4 holds previous 1 into the new period
        8'b001_1_0110,  // R5
        8'b001_0_0000,  // R5
        8'b010_0_1001,  // R6
        8'b010_1_1111,  // R6
        8'b011_1_0110,  // R7
        8'b011_0_1001,  // R7
        8'b100_0_1111,  // R8 constant one
        8'b101_1_0000,  // R8 constant zero
        8'b110_1_0000,  // R9
        8'b111_1_0000,  // R9
        8'b000_1_1111,  // R4
        8'b001_1_0110   // R5
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        chk("R1 drv_data", drv_data, 1'b0);
        chk("R1 drv_en", drv_en, 1'b0);
        chk("R1 load_en", load_en, 1'b0);
        rst_n = 1'b1;

        // vector table, one period of four cycles per entry
        for (int i = 0; i < NVEC; i++) begin
            data_fmt  = VEC[i][7:5];
            en_fmt    = VEC[i][7:5];
            pat_data  = VEC[i][4];
            pat_en    = VEC[i][4];
            load_mode = 2'(i % 4);
            for (int k = 0; k < 4; k++) begin
                logic e;
                logic le;
                cyc_start       = (k == 0);
                data_edge_open  = (k == 1);
                en_edge_open    = (k == 1);
                data_edge_close = (k == 3);
                en_edge_close   = (k == 3);
                tick();
                e = VEC[i][3-k];
                chk($sformatf("R2 data vec%0d c%0d", i, k), drv_data, e);
                chk($sformatf("R2 en vec%0d c%0d", i, k), drv_en, e);
                // R11 load expectation
                le = (load_mode == 2'd0) ? ~e : (load_mode == 2'd1);
                chk($sformatf("R11 load vec%0d c%0d", i, k), load_en, le);
            end
            data_edge_close = 1'b0;
            en_edge_close   = 1'b0;
        end

        // R3 pattern change mid-period is ignored
        data_fmt = 3'd1; en_fmt = 3'd5; load_mode = 2'd0;
        pat_data = 1'b1; cyc_start = 1'b1; tick();
        cyc_start = 1'b0; data_edge_open = 1'b1; tick();
        data_edge_open = 1'b0; pat_data = 1'b0; tick();
        chk("R3 held pattern", drv_data, 1'b1);
        data_edge_close = 1'b1; tick();
        data_edge_close = 1'b0;
        chk("R5 closed", drv_data, 1'b0);

        // R2 open and close in the same cycle leave the window shut
        pat_data = 1'b1; cyc_start = 1'b1; tick();
        cyc_start = 1'b0; data_edge_open = 1'b1; data_edge_close = 1'b1; tick();
        data_edge_open = 1'b0; data_edge_close = 1'b0;
        chk("R2 same-cycle edges", drv_data, 1'b0);

        // R2 new period closes a window left open
        cyc_start = 1'b1; tick();
        cyc_start = 1'b0; data_edge_open = 1'b1; tick();
        data_edge_open = 1'b0;
        chk("R2 window open", drv_data, 1'b1);
        cyc_start = 1'b1; tick();
        cyc_start = 1'b0;
        chk("R2 period start closes", drv_data, 1'b0);

        // R10 enable pulses do not touch the data window
        en_fmt = 3'd1; pat_en = 1'b1;
        cyc_start = 1'b1; tick();
        cyc_start = 1'b0; en_edge_open = 1'b1; tick();
        en_edge_open = 1'b0;
        chk("R10 enable window", drv_en, 1'b1);
        chk("R10 data untouched", drv_data, 1'b0);
        chk("R11 load follows", load_en, 1'b0);

        // R12 code change appears after one edge
        data_fmt = 3'd4; tick();
        chk("R12 high after one edge", drv_data, 1'b1);
        data_fmt = 3'd5;
        #1;
        chk("R12 unchanged before edge", drv_data, 1'b1);
        tick();
        chk("R12 low after one edge", drv_data, 1'b0);
        load_mode = 2'd3; tick();
        chk("R11 code 3 off", load_en, 1'b0);

        finish_run();
    end

endmodule